// File: doc/BRIEF.md
# Max-metric extrinsic LLR unit

This block is the last stage of a stochastic soft-output detector. Several parallel samplers each deliver, on every cycle, two candidate metrics for the bit position they are working on. One metric is for the candidate with that bit forced to zero and one is for the candidate with that bit forced to one. Each metric has its own validity token. The unit keeps, for every bit position of the symbol vector, the largest zero-metric and the largest one-metric seen so far. These maxima span all samplers and all samples except the first one.

A start pulse empties both stores. In the stores, an empty entry stands for minus infinity. A finish pulse then makes the unit stream one extrinsic LLR per bit position, in ascending bit-index order. Each LLR is the zero-maximum minus the one-maximum minus the prior LLR of that bit, saturated. The unit reads the prior through a lookup port: it presents `prior_addr`, and the surrounding logic must return that bit's prior on `prior_llr` in the same cycle.

The metric input is a valid/ready stream. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole output phase, and upstream must hold or withhold beats during that time. The LLR output is a valid/ready stream with one register stage. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. `vec_start` and `vec_finish` are plain single-cycle control pulses.

Top module: `llr_maxlog_unit`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is low and `in_ready` is high.
- R2: A `vec_start` pulse taken while collecting marks every stored entry of both bit values empty. A bit position that receives no valid metric afterwards behaves as empty at output time.
- R3: For each bit value, only lanes whose token is high take part in the maximum (`in_tok0[p]` for lane p of `in_m0`, `in_tok1[p]` for lane p of `in_m1`). A beat with no high token for a bit value leaves that stored entry unchanged.
- R4: An accepted beat with `in_first_sample` high changes no stored entry.
- R5: Each stored entry ends as the largest valid metric of its bit value and bit index over all accepted beats since the last start. Lane p occupies bits [p*24+23 : p*24] of its bus as signed 24-bit values with 5 fraction bits.
- R6: The output for bit b is floor((M0 − M1 − 2·P) / 2). M0 and M1 are the stored maxima for b, in units of 2^-5. P is the signed 9-bit prior (4 fraction bits) that is returned on `prior_llr` while `prior_addr` equals b. The result is a signed 12-bit value with 4 fraction bits.
- R7: Results above 2047 are output as 2047, and results below −2048 are output as −2048.
- R8: An empty stored entry enters the R6 computation as −2^23.
- R9: On the first rising edge after the edge that captures `vec_finish`, the first output is loaded. It is therefore valid after two edges. The outputs then carry `out_idx` 0, 1, … up to NB−1 in that order, with one word per accepted transfer.
- R10: While `out_valid` is high and `out_ready` is low, `out_idx` and `out_llr` hold and `out_valid` stays high.
- R11: `in_ready` falls on the edge that captures `vec_finish` and rises on the edge that accepts the last output. Between those edges, beats, `vec_start` and `vec_finish` have no effect.
- R12: A beat presented in the same cycle as an accepted `vec_start` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_start | input | 1 | Empties both maxima stores |
| vec_finish | input | 1 | Ends collection and starts the output stream |
| in_valid | input | 1 | Metric beat valid |
| in_ready | output | 1 | Unit accepts metric beats |
| in_bit_idx | input | IW (5) | Bit position of the beat |
| in_first_sample | input | 1 | Beat belongs to the first sample; excluded |
| in_tok0 | input | NP (4) | Per-lane validity of the zero-bit metrics |
| in_tok1 | input | NP (4) | Per-lane validity of the one-bit metrics |
| in_m0 | input | NP*MW (96) | Zero-bit candidate metrics, one signed lane per sampler |
| in_m1 | input | NP*MW (96) | One-bit candidate metrics, one signed lane per sampler |
| prior_addr | output | IW (5) | Bit position whose prior is needed this cycle |
| prior_llr | input | PW (9) | Prior LLR for `prior_addr`, returned in the same cycle |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_idx | output | IW (5) | Bit position of the output word |
| out_llr | output | OW (12) | Saturated extrinsic LLR |

## Verification
The assertions check the stream discipline on every cycle. They check that the output word holds under back-pressure and that `in_ready` stays low while output is pending. They also check that the output index steps by one and starts at zero, that the input reopens right after the last word, and that a finish closes the input. The arithmetic content can only be shown by the bench's scenarios, which a behavioural model scores. This covers maxima built only from valid lanes, first-sample beats that carry huge metrics and must leave no trace, entries left empty by a start, and one-sided empty entries that drive saturation. The same applies to the exact two-edge latency after finish and to pulses sent during output that must change nothing.

// File: rtl/llr_pkg.sv
package llr_pkg;
  // Two stores exist: one per hypothesised bit value.
  localparam int BIT_VALUES = 2;

  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_DRAIN   = 1'b1
  } phase_e;
endpackage

// File: rtl/llr_cs_tree.sv
// Compare-select reduction over NP lanes; an invalid lane never wins.
module llr_cs_tree #(
  parameter int NP = 4,
  parameter int W  = 24
) (
  input  logic [NP*W-1:0]       lane_v,
  input  logic [NP-1:0]         lane_t,
  output logic signed [W-1:0]   best_v,
  output logic                  best_t
);
  localparam int LVL   = (NP > 1) ? $clog2(NP) : 0;
  localparam int P2    = 1 << LVL;
  localparam int NODES = 2 * P2 - 1;

  logic signed [W-1:0] nd_v [NODES];
  logic                nd_t [NODES];

  for (genvar gl = 0; gl < P2; gl++) begin : g_leaf
    if (gl < NP) begin : g_used
      assign nd_v[P2-1+gl] = lane_v[gl*W +: W];
      assign nd_t[P2-1+gl] = lane_t[gl];
    end else begin : g_pad
      assign nd_v[P2-1+gl] = '0;
      assign nd_t[P2-1+gl] = 1'b0;
    end
  end

  for (genvar gk = 0; gk < P2 - 1; gk++) begin : g_node
    logic take_r;
    assign take_r = nd_t[2*gk+2] &&
                    (!nd_t[2*gk+1] || (nd_v[2*gk+2] > nd_v[2*gk+1]));
    assign nd_v[gk] = take_r ? nd_v[2*gk+2] : nd_v[2*gk+1];
    assign nd_t[gk] = nd_t[2*gk+1] | nd_t[2*gk+2];
  end

  assign best_v = nd_v[0];
  assign best_t = nd_t[0];
endmodule

// File: rtl/llr_max_bank.sv
// One store of running maxima with a validity token per entry.
module llr_max_bank #(
  parameter int NP = 4,
  parameter int NB = 24,
  parameter int MW = 24,
  parameter int IW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic [IW-1:0]        upd_idx,
  input  logic [NP*MW-1:0]     lane_v,
  input  logic [NP-1:0]        lane_t,
  input  logic [IW-1:0]        rd_idx,
  output logic signed [MW-1:0] rd_v,
  output logic                 rd_t
);
  logic signed [MW-1:0] best_v;
  logic                 best_t;

  llr_cs_tree #(.NP(NP), .W(MW)) u_tree (
    .lane_v (lane_v),
    .lane_t (lane_t),
    .best_v (best_v),
    .best_t (best_t)
  );

  logic signed [MW-1:0] ent_v [NB];
  logic [NB-1:0]        ent_t;
  logic                 idx_ok;
  logic signed [MW-1:0] cur_v;
  logic                 cur_t;
  logic                 win;

  always_comb begin
    idx_ok = int'(upd_idx) < NB;
    cur_v  = idx_ok ? ent_v[upd_idx] : '0;
    cur_t  = idx_ok ? ent_t[upd_idx] : 1'b0;
    win    = upd && idx_ok && best_t && (!cur_t || (best_v > cur_v));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_t <= '0;
      for (int i = 0; i < NB; i++) ent_v[i] <= '0;
    end else if (clr) begin
      ent_t <= '0;
    end else if (win) begin
      ent_v[upd_idx] <= best_v;
      ent_t[upd_idx] <= 1'b1;
    end
  end

  assign rd_v = ent_v[rd_idx];
  assign rd_t = ent_t[rd_idx];
endmodule

// File: rtl/llr_extrinsic.sv
// Difference of maxima minus prior, realigned and saturated.
module llr_extrinsic #(
  parameter int MW = 24,
  parameter int PW = 9,
  parameter int OW = 12,
  parameter int MF = 5,
  parameter int PF = 4,
  parameter int OF = 4
) (
  input  logic signed [MW-1:0] m0,
  input  logic                 t0,
  input  logic signed [MW-1:0] m1,
  input  logic                 t1,
  input  logic signed [PW-1:0] prior,
  output logic signed [OW-1:0] llr
);
  localparam int XW  = MW + 3;
  localparam int PSH = MF - PF;
  localparam int OSH = MF - OF;
  localparam logic signed [XW-1:0] NEG_M = {{(XW-MW+1){1'b1}}, {(MW-1){1'b0}}};
  localparam logic signed [XW-1:0] OMAX  = {{(XW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [XW-1:0] OMIN  = {{(XW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [XW-1:0] a, b, p, r, q;

  always_comb begin
    a = t0 ? {{(XW-MW){m0[MW-1]}}, m0} : NEG_M;
    b = t1 ? {{(XW-MW){m1[MW-1]}}, m1} : NEG_M;
    p = {{(XW-PW){prior[PW-1]}}, prior} <<< PSH;
    r = a - b - p;
    q = r >>> OSH;
    if (q > OMAX)      llr = OMAX[OW-1:0];
    else if (q < OMIN) llr = OMIN[OW-1:0];
    else               llr = q[OW-1:0];
  end
endmodule

// File: rtl/llr_maxlog_unit.sv
module llr_maxlog_unit #(
  parameter int NP = 4,
  parameter int NB = 24,
  parameter int MW = 24,
  parameter int PW = 9,
  parameter int OW = 12,
  parameter int MF = 5,
  parameter int PF = 4,
  parameter int OF = 4,
  parameter int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_start,
  input  logic              vec_finish,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IW-1:0]     in_bit_idx,
  input  logic              in_first_sample,
  input  logic [NP-1:0]     in_tok0,
  input  logic [NP-1:0]     in_tok1,
  input  logic [NP*MW-1:0]  in_m0,
  input  logic [NP*MW-1:0]  in_m1,
  output logic [IW-1:0]     prior_addr,
  input  logic [PW-1:0]     prior_llr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IW-1:0]     out_idx,
  output logic [OW-1:0]     out_llr
);
  import llr_pkg::*;

  localparam int CW = $clog2(NB + 1);

  phase_e         phase;
  logic [CW-1:0]  cnt;
  logic           collecting, clr, upd, load, last_take;

  logic [NP*MW-1:0]     lane_v [BIT_VALUES];
  logic [NP-1:0]        lane_t [BIT_VALUES];
  logic signed [MW-1:0] rd_v   [BIT_VALUES];
  logic                 rd_t   [BIT_VALUES];
  logic signed [OW-1:0] llr_c;

  assign collecting = (phase == PH_COLLECT);
  assign in_ready   = collecting;
  assign clr        = collecting && vec_start;
  assign upd        = collecting && in_valid && !vec_start && !in_first_sample;
  assign load       = !collecting && (cnt < CW'(NB)) && (!out_valid || out_ready);
  assign last_take  = !collecting && out_valid && out_ready && (cnt == CW'(NB));
  assign prior_addr = (cnt < CW'(NB)) ? cnt[IW-1:0] : '0;

  assign lane_v[0] = in_m0;
  assign lane_v[1] = in_m1;
  assign lane_t[0] = in_tok0;
  assign lane_t[1] = in_tok1;

  for (genvar gb = 0; gb < BIT_VALUES; gb++) begin : g_bank
    llr_max_bank #(.NP(NP), .NB(NB), .MW(MW), .IW(IW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .upd     (upd),
      .upd_idx (in_bit_idx),
      .lane_v  (lane_v[gb]),
      .lane_t  (lane_t[gb]),
      .rd_idx  (prior_addr),
      .rd_v    (rd_v[gb]),
      .rd_t    (rd_t[gb])
    );
  end

  llr_extrinsic #(.MW(MW), .PW(PW), .OW(OW), .MF(MF), .PF(PF), .OF(OF)) u_ext (
    .m0    (rd_v[0]),
    .t0    (rd_t[0]),
    .m1    (rd_v[1]),
    .t1    (rd_t[1]),
    .prior (prior_llr),
    .llr   (llr_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_COLLECT;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_llr   <= '0;
    end else if (collecting) begin
      if (vec_finish) begin
        phase <= PH_DRAIN;
        cnt   <= '0;
      end
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_idx   <= cnt[IW-1:0];
        out_llr   <= llr_c;
        cnt       <= cnt + 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (last_take) phase <= PH_COLLECT;
    end
  end
endmodule

// File: rtl/llr_maxlog_chk.sv
module llr_maxlog_chk #(
  parameter int NB = 24,
  parameter int IW = 5,
  parameter int OW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vec_finish,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_idx,
  input logic [OW-1:0] out_llr
);
  // R11: input stays closed while an output word is pending
  p_ready_low_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10: a stalled word holds
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_llr) && $stable(out_idx));

  // R9: indices step by one between accepted words
  p_index_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (out_idx != IW'(NB-1))
    |=> out_valid && (out_idx == IW'($past(out_idx) + 1'b1)));

  // R9: the stream opens at index zero
  p_first_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_idx == '0);

  // R11: input reopens on the edge that takes the last word
  p_release_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (out_idx == IW'(NB-1)) |=> in_ready && !out_valid);

  // R11: a finish closes the input on the next edge
  p_finish_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && vec_finish |=> !in_ready && !out_valid);
endmodule

bind llr_maxlog_unit llr_maxlog_chk #(.NB(NB), .IW(IW), .OW(OW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vec_finish (vec_finish),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_idx    (out_idx),
  .out_llr    (out_llr)
);

// File: tb/test_llr_maxlog_unit.sv
`timescale 1ns/1ps
module test_llr_maxlog_unit;
  localparam int NP = 4;
  localparam int NB = 24;
  localparam int MW = 24;
  localparam int PW = 9;
  localparam int OW = 12;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_start = 1'b0, vec_finish = 1'b0, in_valid = 1'b0, in_first_sample = 1'b0;
  logic in_ready;
  logic [IW-1:0] in_bit_idx = '0;
  logic [NP-1:0] in_tok0 = '0, in_tok1 = '0;
  logic [NP*MW-1:0] in_m0 = '0, in_m1 = '0;
  logic [IW-1:0] prior_addr;
  logic [PW-1:0] prior_llr;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [IW-1:0] out_idx;
  logic [OW-1:0] out_llr;

  always #5 clk = ~clk;

  llr_maxlog_unit i_llr_maxlog_unit (
    .clk(clk), .rst_n(rst_n), .vec_start(vec_start), .vec_finish(vec_finish),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit_idx(in_bit_idx),
    .in_first_sample(in_first_sample), .in_tok0(in_tok0), .in_tok1(in_tok1),
    .in_m0(in_m0), .in_m1(in_m1), .prior_addr(prior_addr), .prior_llr(prior_llr),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_llr(out_llr)
  );

  int prior_tab [NB];
  always_comb prior_llr = (int'(prior_addr) < NB) ? prior_tab[prior_addr][PW-1:0] : '0;

  int compared = 0, mismatched = 0;
  string cur_tag = "R6";
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int  mx0 [NB], mx1 [NB];
  bit  v0 [NB], v1 [NB];
  bit  m_drain = 0, m_last = 0;
  int  exp_idx_q[$], exp_llr_q[$];

  function automatic int calc(int b);
    int a, c, r, q;
    a = v0[b] ? mx0[b] : -(1 << (MW-1));   // R8
    c = v1[b] ? mx1[b] : -(1 << (MW-1));
    r = a - c - 2 * prior_tab[b];           // R6
    q = r >>> 1;
    if (q > 2047) q = 2047;                 // R7
    if (q < -2048) q = -2048;
    return q;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_drain = 0; m_last = 0;
      for (int i = 0; i < NB; i++) begin v0[i] = 0; v1[i] = 0; end
      exp_idx_q.delete(); exp_llr_q.delete();
    end else if (m_drain) begin
      if (m_last) begin m_drain = 0; m_last = 0; end
    end else begin
      if (vec_start) begin
        for (int i = 0; i < NB; i++) begin v0[i] = 0; v1[i] = 0; end
      end else if (in_valid && !in_first_sample && int'(in_bit_idx) < NB) begin
        for (int p = 0; p < NP; p++) begin
          int a, c;
          a = $signed(in_m0[p*MW +: MW]);
          c = $signed(in_m1[p*MW +: MW]);
          if (in_tok0[p] && (!v0[in_bit_idx] || a > mx0[in_bit_idx])) begin
            mx0[in_bit_idx] = a; v0[in_bit_idx] = 1;
          end
          if (in_tok1[p] && (!v1[in_bit_idx] || c > mx1[in_bit_idx])) begin
            mx1[in_bit_idx] = c; v1[in_bit_idx] = 1;
          end
        end
      end
      if (vec_finish) begin
        for (int b = 0; b < NB; b++) begin
          exp_idx_q.push_back(b);
          exp_llr_q.push_back(calc(b));
        end
        m_drain = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(in_ready == !m_drain, "R11", "in_ready", in_ready, !m_drain);
      if (!m_drain) chk(out_valid == 1'b0, "R9", "out_valid while collecting", out_valid, 0);
      if (out_valid && out_ready) begin
        if (exp_idx_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected output word", out_idx, -1);
        end else begin
          int ei, el;
          ei = exp_idx_q.pop_front();
          el = exp_llr_q.pop_front();
          chk(out_idx == IW'(ei), "R9", "out_idx", out_idx, ei);
          chk($signed(out_llr) == el, cur_tag, "out_llr", $signed(out_llr), el);
          if (exp_idx_q.size() == 0) m_last = 1;
        end
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rnd_lanes(input int lo0, input int hi0, input int lo1, input int hi1);
    for (int p = 0; p < NP; p++) begin
      int a, c;
      a = lo0 + int'($urandom_range(hi0 - lo0));
      c = lo1 + int'($urandom_range(hi1 - lo1));
      in_m0[p*MW +: MW] = a[MW-1:0];
      in_m1[p*MW +: MW] = c[MW-1:0];
    end
  endtask

  task automatic beat(input int idx, input bit sz, input logic [NP-1:0] t0, input logic [NP-1:0] t1,
                      input int lo0, input int hi0, input int lo1, input int hi1);
    in_valid = 1; in_bit_idx = idx[IW-1:0]; in_first_sample = sz;
    in_tok0 = t0; in_tok1 = t1;
    rnd_lanes(lo0, hi0, lo1, hi1);
    step();
    in_valid = 0; in_first_sample = 0;
  endtask

  task automatic pulse_start();
    vec_start = 1; step(); vec_start = 0;
  endtask

  task automatic new_priors(input int lim);
    for (int b = 0; b < NB; b++) prior_tab[b] = int'($urandom_range(2*lim)) - lim;
  endtask

  task automatic finish_and_drain(input bit lat, input bit bp, input bit disturb);
    vec_finish = 1; step(); vec_finish = 0;
    if (lat) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "out_valid one edge after finish", out_valid, 0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R9", "out_valid two edges after finish", out_valid, 1);
      chk(out_idx == '0, "R9", "first index", out_idx, 0);
      @(posedge clk); #2;
    end
    for (int k = 0; m_drain; k++) begin
      out_ready = bp ? 1'($urandom_range(1)) : 1'b1;
      if (disturb && (k == 5)) begin   // R11: ignored while draining
        vec_start = 1; vec_finish = 1; in_valid = 1; in_bit_idx = 2;
        in_tok0 = '1; in_tok1 = '1; rnd_lanes(8000000, 8300000, -8300000, -8000000);
      end else begin
        vec_start = 0; vec_finish = 0; in_valid = 0;
      end
      step();
    end
    out_ready = 1; vec_start = 0; vec_finish = 0; in_valid = 0;
    step();
  endtask

  initial begin
    for (int b = 0; b < NB; b++) prior_tab[b] = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "idle after reset", {out_valid, in_ready}, 1);
    step();

    // Vector A: maxima over valid lanes, first-sample beats with huge metrics
    cur_tag = "R3 R4 R5 R6";
    new_priors(255);
    pulse_start();
    for (int i = 0; i < 120; i++) begin
      if (i % 7 == 3)
        beat(int'($urandom_range(NB-1)), 1, '1, '1, 8000000, 8300000, 8000000, 8300000);
      else
        beat(int'($urandom_range(NB-1)), 0, NP'($urandom), NP'($urandom), -2000, 2000, -2000, 2000);
    end
    finish_and_drain(1, 0, 0);

    // Vector B: back-pressure and pulses during output
    cur_tag = "R10 R11 R5";
    new_priors(200);
    pulse_start();
    for (int i = 0; i < 150; i++)
      beat(i % NB, 0, NP'($urandom), NP'($urandom), -900, 900, -900, 900);
    finish_and_drain(0, 1, 1);

    // Vector C: clearing, empty entries, start-coincident beat
    cur_tag = "R2 R8 R12 R3";
    new_priors(255);
    vec_start = 1; in_valid = 1; in_bit_idx = 3; in_tok0 = '1; in_tok1 = '1;
    rnd_lanes(5000000, 6000000, 5000000, 6000000);
    step();
    vec_start = 0; in_valid = 0;
    beat(0, 0, '1, '0, -1000, 1000, -1000, 1000);
    beat(1, 0, '0, '1, -1000, 1000, -1000, 1000);
    beat(2, 0, 4'b0101, 4'b1010, -1000, 1000, -1000, 1000);
    beat(4, 0, '0, '0, 7000000, 8000000, -8000000, -7000000);
    finish_and_drain(0, 0, 0);

    // Vector D: saturation in both directions
    cur_tag = "R7";
    new_priors(255);
    pulse_start();
    for (int i = 0; i < 2 * NB; i++) begin
      if ((i % NB) % 2 == 0)
        beat(i % NB, 0, '1, '1, 4000000, 8000000, -8000000, -4000000);
      else
        beat(i % NB, 0, '1, '1, -8000000, -4000000, 4000000, 8000000);
    end
    finish_and_drain(1, 1, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule